// File: doc/BRIEF.md
# Round-Trip-Aware Link Receive Buffer

This block is the receiving end of a ready/valid link in which words take several register stages to travel forward and the ready indication takes several register stages to travel back. Because the sender reacts to ready only after the backward delay, and because words already launched keep arriving, the receiver cannot simply report "not full". Instead it counts its free slots and opens the link only while enough room remains to absorb every word that could still be in flight.

The threshold is set by the round trip. In the plain mode it is the sum of the forward and backward stage counts. In the tightened mode the sender's own output register holds its word when ready is low, so one fewer slot is needed. The buffer depth is that threshold plus an extra allowance. An allowance equal to the threshold lets the link run at full rate after a stall. Buffered words leave in arrival order through an ordinary valid/ready output port. A word that arrives with no free slot is discarded and latches an error flag.

Top module: `rvb_link_rx`

## Requirements
- R1: After reset the buffer is empty: `free_slots` equals the depth, `out_valid` is 0, `link_ready` is 1 and `overflow_err` is 0.
- R2: The threshold is FWD_STAGES+BWD_STAGES-1 when TIGHT_MODE is 1, and FWD_STAGES+BWD_STAGES when it is 0. The depth is the threshold plus EXTRA_SLOTS, and `free_slots` never exceeds the depth. With the defaults (2, 2, tight mode, 3 extra) the threshold is 3 and the depth is 6.
- R3: `link_ready` is 1 in a cycle exactly when `free_slots` plus one more for a dequeue taking place in that same cycle is at least the threshold. The dequeue counts at once, before the count register updates.
- R4: An `in_valid` word that arrives while `free_slots` is nonzero is stored, and `free_slots` drops by one at the next clock edge unless a dequeue happens in the same cycle.
- R5: An enqueue and a dequeue in the same cycle leave `free_slots` unchanged.
- R6: While `out_valid` is 1, `out_data` shows the oldest stored word. It is removed at the clock edge where `out_valid` and `out_ready` are both 1, so words leave in arrival order.
- R7: An `in_valid` word that arrives while `free_slots` is 0 is discarded, even if a dequeue happens in that cycle. It sets `overflow_err` at the next edge, and the flag stays set until reset.
- R8: `out_valid` is 1 exactly when at least one word is stored.
- R9: Starting from a full buffer with no arrivals and `out_ready` held at 1, `link_ready` first returns to 1 in the cycle in which the threshold-th word is dequeued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A link word arrives this cycle |
| in_data | input | DW | Arriving word |
| link_ready | output | 1 | Ready sent back toward the sender |
| out_valid | output | 1 | A buffered word is available |
| out_data | output | DW | Oldest buffered word |
| out_ready | input | 1 | The consumer takes the word this cycle |
| free_slots | output | $clog2(DEPTH+1) | Number of free slots |
| overflow_err | output | 1 | Sticky flag: a word was discarded |

## Verification
`link_ready`, `out_valid` and `out_data` are combinational in the current cycle. `link_ready` depends on the dequeue under way in that cycle. `free_slots`, the storage and `overflow_err` change one clock edge after the stimulus that moves them. The bench drives its inputs 1 ns after a rising edge and samples at the following falling edge. At that point the combinational results for the coming edge are settled, and the effects of the previous edge are visible. A scoreboard model is updated at that same sample point to predict the state after the coming edge. The R9 check counts dequeues cycle by cycle from a full buffer and compares the count at the first sample where ready is high.

// File: rtl/rvb_pkg.sv
package rvb_pkg;

  // Words that may still arrive after ready falls.
  function automatic int unsigned rtt_slots(input int unsigned fwd,
                                            input int unsigned bwd,
                                            input bit          tight);
    return tight ? (fwd + bwd - 1) : (fwd + bwd);
  endfunction

  // Free count after one cycle with an accepted enqueue and/or dequeue.
  function automatic int unsigned free_step(input int unsigned free_now,
                                            input bit          enq,
                                            input bit          deq);
    return free_now - int'(enq) + int'(deq);
  endfunction

  // Ready decision: a dequeue this cycle already counts as room.
  function automatic bit ready_open(input int unsigned free_now,
                                    input bit          deq,
                                    input int unsigned thresh);
    return (free_now + int'(deq)) >= thresh;
  endfunction

endpackage

// File: rtl/rvb_store.sv
module rvb_store #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 6,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data
);

  logic [AW-1:0] wr_ptr_q;
  logic [AW-1:0] rd_ptr_q;
  logic [DW-1:0] slot_w [DEPTH];

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (wr_en) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (rd_en) rd_ptr_q <= ptr_inc(rd_ptr_q);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [DW-1:0] cell_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                             cell_q <= '0;
      else if (wr_en && wr_ptr_q == AW'(g))   cell_q <= wr_data;
    end
    assign slot_w[g] = cell_q;
  end

  assign rd_data = slot_w[rd_ptr_q];

endmodule

// File: rtl/rvb_slot_counter.sv
module rvb_slot_counter #(
  parameter int unsigned DEPTH = 6,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          deq,
  output logic          enq,
  output logic          drop,
  output logic [CW-1:0] free_slots,
  output logic          overflow_err
);

  logic [CW-1:0] free_q;
  logic          ovf_q;
  logic          no_room;

  assign no_room = (free_q == '0);
  assign enq     = in_valid && !no_room;
  assign drop    = in_valid && no_room;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_q <= CW'(DEPTH);
      ovf_q  <= 1'b0;
    end else begin
      free_q <= CW'(rvb_pkg::free_step(32'(free_q), enq, deq));
      if (drop) ovf_q <= 1'b1;
    end
  end

  assign free_slots   = free_q;
  assign overflow_err = ovf_q;

endmodule

// File: rtl/rvb_ready_gen.sv
module rvb_ready_gen #(
  parameter int unsigned THRESH = 3,
  parameter int unsigned CW     = 3
) (
  input  logic [CW-1:0] free_slots,
  input  logic          deq,
  output logic          link_ready
);

  assign link_ready = rvb_pkg::ready_open(32'(free_slots), deq, THRESH);

endmodule

// File: rtl/rvb_link_rx.sv
module rvb_link_rx #(
  parameter int unsigned DW          = 8,
  parameter int unsigned FWD_STAGES  = 2,
  parameter int unsigned BWD_STAGES  = 2,
  parameter int unsigned EXTRA_SLOTS = 3,
  parameter bit          TIGHT_MODE  = 1'b1,
  localparam int unsigned THRESH = rvb_pkg::rtt_slots(FWD_STAGES, BWD_STAGES, TIGHT_MODE),
  localparam int unsigned DEPTH  = THRESH + EXTRA_SLOTS,
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          link_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  output logic [CW-1:0] free_slots,
  output logic          overflow_err
);

  // Named internal events for the checker.
  logic enq_fire;
  logic deq_fire;
  logic drop_evt;

  assign out_valid = (free_slots != CW'(DEPTH));
  assign deq_fire  = out_valid && out_ready;

  rvb_slot_counter #(.DEPTH(DEPTH)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .deq          (deq_fire),
    .enq          (enq_fire),
    .drop         (drop_evt),
    .free_slots   (free_slots),
    .overflow_err (overflow_err)
  );

  rvb_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (enq_fire),
    .wr_data (in_data),
    .rd_en   (deq_fire),
    .rd_data (out_data)
  );

  rvb_ready_gen #(.THRESH(THRESH), .CW(CW)) u_rdy (
    .free_slots (free_slots),
    .deq        (deq_fire),
    .link_ready (link_ready)
  );

endmodule

// File: rtl/rvb_link_rx_chk.sv
module rvb_link_rx_chk #(
  parameter int unsigned DEPTH  = 6,
  parameter int unsigned THRESH = 3,
  parameter int unsigned CW     = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          link_ready,
  input logic          out_valid,
  input logic [CW-1:0] free_slots,
  input logic          overflow_err,
  input logic          enq_fire,
  input logic          deq_fire,
  input logic          drop_evt
);

  logic [CW:0] room_w;
  assign room_w = {1'b0, free_slots} + {{CW{1'b0}}, deq_fire};

  p_free_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    free_slots <= CW'(DEPTH));

  p_ready_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    link_ready |-> room_w >= (CW+1)'(THRESH));

  p_ready_shut_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !link_ready |-> room_w < (CW+1)'(THRESH));

  p_enq_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_fire && !deq_fire) |=> free_slots == $past(free_slots) - CW'(1));

  p_count_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_fire && deq_fire) |=> $stable(free_slots));

  p_no_enq_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (free_slots == '0) |-> !enq_fire);

  p_ovf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> overflow_err);

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err |=> overflow_err);

  p_valid_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (free_slots != CW'(DEPTH)));

  p_drop_only_on_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |-> in_valid);

endmodule

bind rvb_link_rx rvb_link_rx_chk #(.DEPTH(DEPTH), .THRESH(THRESH), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .link_ready   (link_ready),
  .out_valid    (out_valid),
  .free_slots   (free_slots),
  .overflow_err (overflow_err),
  .enq_fire     (enq_fire),
  .deq_fire     (deq_fire),
  .drop_evt     (drop_evt)
);

// File: tb/sim_rvb_link_rx.sv
`timescale 1ns/1ps
module sim_rvb_link_rx;

  localparam int DW     = 8;
  localparam int THRESH = 3;   // 2 + 2 - 1, tight mode (R2)
  localparam int DEPTH  = 6;   // THRESH + 3 extra (R2)
  localparam int CW     = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_ready = 1'b0;
  logic          link_ready, out_valid, overflow_err;
  logic [DW-1:0] out_data;
  logic [CW-1:0] free_slots;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] seq = 8'h10;

  // scoreboard model
  logic [DW-1:0] exp_q[$];
  int  m_free = DEPTH;
  bit  m_ovf  = 1'b0;

  always #2 clk = ~clk;

  rvb_link_rx u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .link_ready(link_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .free_slots(free_slots), .overflow_err(overflow_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Monitor: samples at falling edge, predicts the coming rising edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      m_free = DEPTH;
      m_ovf  = 1'b0;
      exp_q.delete();
    end else begin
      bit pop, push;
      pop  = out_ready && (m_free != DEPTH);
      push = in_valid && (m_free > 0);
      chk(int'(free_slots) == m_free, "R4 free_slots", int'(free_slots), m_free);
      chk(out_valid == (m_free != DEPTH), "R8 out_valid", int'(out_valid), int'(m_free != DEPTH));
      chk(link_ready == ((m_free + int'(pop)) >= THRESH), "R3 link_ready",
          int'(link_ready), int'((m_free + int'(pop)) >= THRESH));
      chk(overflow_err == m_ovf, "R7 overflow_err", int'(overflow_err), int'(m_ovf));
      if (pop) begin
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected word", int'(out_data), -1);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(out_data == e, "R6 out_data order", int'(out_data), int'(e));
        end
      end
      if (push) exp_q.push_back(in_data);
      if (in_valid && m_free == 0) m_ovf = 1'b1;
      m_free = m_free - int'(push) + int'(pop);
    end
  end

  // Driver: called 1 ns after a rising edge, returns 1 ns after a later one.
  task automatic drive(input bit v, input bit r, input int n);
    for (int i = 0; i < n; i++) begin
      in_valid  = v;
      in_data   = seq;
      out_ready = r;
      if (v) seq = seq + 8'd1;
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    do_reset();
    @(negedge clk); #0.5;
    // R1 reset state
    chk(int'(free_slots) == DEPTH, "R1 free after reset", int'(free_slots), DEPTH);
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(link_ready == 1'b1, "R1 link_ready after reset", int'(link_ready), 1);
    chk(overflow_err == 1'b0, "R1 overflow after reset", int'(overflow_err), 0);
    @(posedge clk); #1;

    // R2: exactly DEPTH words fit
    drive(1'b1, 1'b0, DEPTH);
    @(negedge clk); #0.5;
    chk(int'(free_slots) == 0, "R2 full after depth words", int'(free_slots), 0);
    chk(link_ready == 1'b0, "R3 ready low when full", int'(link_ready), 0);
    @(posedge clk); #1;

    // R9: drain from full, ready rises with the THRESH-th dequeue
    begin
      int pops = 0;
      bit seen = 1'b0;
      out_ready = 1'b1;
      for (int c = 0; c < DEPTH && !seen; c++) begin
        @(negedge clk); #0.5;
        if (out_valid && out_ready) pops++;
        if (link_ready) begin
          seen = 1'b1;
          chk(pops == THRESH, "R9 ready rise cycle", pops, THRESH);
        end
        @(posedge clk); #1;
      end
      if (!seen) chk(1'b0, "R9 ready never rose", 0, 1);
    end
    drive(1'b0, 1'b1, DEPTH);

    // R5: two words stored, then enqueue and dequeue together
    drive(1'b1, 1'b0, 2);
    for (int c = 0; c < 8; c++) begin
      in_valid = 1'b1; in_data = seq; seq = seq + 8'd1; out_ready = 1'b1;
      @(negedge clk); #0.5;
      chk(int'(free_slots) == DEPTH - 2, "R5 count held", int'(free_slots), DEPTH - 2);
      @(posedge clk); #1;
    end
    drive(1'b0, 1'b1, DEPTH);

    // Mixed traffic, ready honoured by the sender
    begin
      logic [7:0] lf = 8'h5A;
      for (int c = 0; c < 400; c++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        #0.1;
        drive(link_ready && (lf[0] | lf[1]), lf[2] | lf[5], 1);
      end
    end
    drive(1'b0, 1'b1, DEPTH);

    // R7: overflow with a dequeue in the same cycle still discards
    drive(1'b1, 1'b0, DEPTH);
    drive(1'b1, 1'b1, 1);
    @(negedge clk); #0.5;
    chk(overflow_err == 1'b1, "R7 overflow set", int'(overflow_err), 1);
    chk(int'(free_slots) == 1, "R7 dropped word not stored", int'(free_slots), 1);
    @(posedge clk); #1;
    drive(1'b0, 1'b1, DEPTH + 2);
    @(negedge clk); #0.5;
    chk(overflow_err == 1'b1, "R7 overflow sticky", int'(overflow_err), 1);
    chk(out_valid == 1'b0, "R8 empty after drain", int'(out_valid), 0);
    @(posedge clk); #1;

    do_reset();
    @(negedge clk); #0.5;
    chk(overflow_err == 1'b0, "R7 cleared by reset", int'(overflow_err), 0);
    chk(link_ready == 1'b1, "R1 ready after second reset", int'(link_ready), 1);
    finish_run();
  end

endmodule